// File: doc/BRIEF.md
# Recursive Vedic Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Rather than a shift-and-add or Booth array, it is built as a tree. A 2x2 cell forms four single-bit partial products and combines them crosswise. Each wider level splits both operands into upper and lower halves. It feeds the four half-width pairings to four sub-multipliers that run in parallel, then adds their shifted results into a product twice the level width. The split repeats until 2-bit pieces remain.

The operand width is a power-of-two parameter from 2 to 32. A second parameter chooses the output stage. With it set, the product is captured in a register on the rising clock edge, and a synchronous active-high reset clears that register. With it cleared, the path from operands to product is purely combinational. The block is meant to be the multiplier inside a larger arithmetic datapath. It has no accumulator and no signed mode.

Top module: `vedic_mult`

## Requirements
- R1: For any unsigned operands `op_x` and `op_y`, the output `prod` equals `op_x * op_y` over the full 2N bits, with no truncation.
- R2: In the 2-bit case, bit 0 is `x0&y0`. Bit 1 is the low bit of `x1&y0 + x0&y1`. Bits 3:2 are `x1&y1` plus the carry of that cross sum, so all 16 operand pairs match the true product.
- R3: When both operands are all ones, the product is 2^(2N) - 2^(N+1) + 1. No carry is lost in any recombining addition.
- R4: For N=8, operands 13 (binary 1101) and 10 (binary 1010) give 130 (binary 10000010).
- R5: If either operand is zero, the product is zero.
- R6: If one operand is 1, the product equals the other operand, zero-extended to 2N bits.
- R7: With `REG_OUT=1`, the product of operands present at a rising edge appears on `prod` after that edge. It stays unchanged until the next edge, whatever the operands do in between.
- R8: With `REG_OUT=1`, `prod` is zero after any edge at which `rst` is high, whatever the operands.
- R9: With `REG_OUT=0`, `prod` follows the operands within the same cycle, with no clock edge needed.
- R10: The same recursive structure gives correct products for N of 2, 8 and 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_x | input | N | First unsigned operand |
| op_y | input | N | Second unsigned operand |
| prod | output | 2N | Unsigned product |

## Verification
The bench runs every operand pair at N=8 and at N=2. A recombination adder that is one bit too narrow would drop the carry into the top bits. That error only shows near all-ones operands, which is why the exhaustive sweep and the explicit all-ones checks matter. A cell with the crosswise carry routed to the wrong bit would fail the 2-bit sweep and the 13 by 10 case. A mis-shifted cross term would break products whose operands straddle the half boundary. At N=32 the bench drives random values together with zero, one and all-ones through the combinational variant. Reset applied both at the start and in the middle of traffic would catch a register that loads operands while reset is high. Sampling between edges would catch an output register that is transparent or captures on the wrong edge.

// File: rtl/vm_pkg.sv
package vm_pkg;
  localparam int unsigned VM_MIN_W = 2;
  localparam int unsigned VM_MAX_W = 32;

  function automatic int unsigned vm_prod_w(input int unsigned n);
    return 2 * n;
  endfunction

  function automatic bit vm_width_ok(input int unsigned n);
    return (n >= VM_MIN_W) && (n <= VM_MAX_W) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/vm_cell2.sv
module vm_cell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] s
);
  logic       t_ll, t_lh, t_hl, t_hh;
  logic [1:0] cross_sum;
  logic [1:0] upper;

  // vertical and crosswise single-bit terms
  assign t_ll = a[0] & b[0];
  assign t_lh = a[0] & b[1];
  assign t_hl = a[1] & b[0];
  assign t_hh = a[1] & b[1];

  assign cross_sum = {1'b0, t_lh} + {1'b0, t_hl};
  assign upper     = {1'b0, t_hh} + {1'b0, cross_sum[1]};

  assign s = {upper, cross_sum[0], t_ll};
endmodule

// File: rtl/vm_recombine.sv
module vm_recombine #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]   pp_ll,
  input  logic [W-1:0]   pp_lh,
  input  logic [W-1:0]   pp_hl,
  input  logic [W-1:0]   pp_hh,
  output logic [2*W-1:0] p
);
  localparam int unsigned H = W / 2;

  logic [W:0]     mid;
  logic [2*W-1:0] outer;
  logic [2*W-1:0] mid_shifted;

  // cross terms keep their carry in the extra bit
  assign mid         = {1'b0, pp_lh} + {1'b0, pp_hl};
  // high and low terms never overlap, so they simply concatenate
  assign outer       = {pp_hh, pp_ll};
  assign mid_shifted = {{(H - 1){1'b0}}, mid, {H{1'b0}}};
  assign p           = outer + mid_shifted;
endmodule

// File: rtl/vm_node.sv
module vm_node #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int unsigned H = W / 2;

  generate
    if (W == 2) begin : g_leaf
      vm_cell2 u_cell (.a(a), .b(b), .s(p));
    end else begin : g_split
      logic [W-1:0] pp_ll, pp_lh, pp_hl, pp_hh;

      vm_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pp_ll));
      vm_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(pp_lh));
      vm_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(pp_hl));
      vm_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(pp_hh));

      vm_recombine #(.W(W)) u_sum (
        .pp_ll(pp_ll), .pp_lh(pp_lh), .pp_hl(pp_hl), .pp_hh(pp_hh), .p(p)
      );
    end
  endgenerate
endmodule

// File: rtl/vm_outstage.sv
module vm_outstage #(
  parameter int unsigned W   = 16,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/vedic_mult.sv
module vedic_mult #(
  parameter int unsigned N       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N-1:0]                 op_x,
  input  logic [N-1:0]                 op_y,
  output logic [vm_pkg::vm_prod_w(N)-1:0] prod
);
  localparam int unsigned PW = vm_pkg::vm_prod_w(N);
  localparam bit          CFG_OK = vm_pkg::vm_width_ok(N);

  logic [PW-1:0] tree_p;

  generate
    if (CFG_OK) begin : g_tree
      vm_node #(.W(N)) u_root (.a(op_x), .b(op_y), .p(tree_p));
    end else begin : g_bad_cfg
      assign tree_p = '0;
    end
  endgenerate

  vm_outstage #(.W(PW), .REG(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .d(tree_p), .q(prod)
  );
endmodule

// File: rtl/vm_chk.sv
module vm_chk #(
  parameter int unsigned N       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      op_x,
  input logic [N-1:0]      op_y,
  input logic [2*N-1:0]    prod
);
  localparam int unsigned PW = 2 * N;

  logic [PW-1:0] ref_p;
  logic [PW-1:0] y_ext;
  logic          x_zero, y_zero, x_one, both_ones;

  assign ref_p     = {{N{1'b0}}, op_x} * {{N{1'b0}}, op_y};
  assign y_ext     = {{N{1'b0}}, op_y};
  assign x_zero    = (op_x == '0);
  assign y_zero    = (op_y == '0);
  assign x_one     = (op_x == {{(N-1){1'b0}}, 1'b1});
  assign both_ones = (op_x == '1) && (op_y == '1);

  generate
    if (REG_OUT) begin : g_reg_props
      p_product_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> prod == $past(ref_p));
      p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(x_zero) || $past(y_zero))) |-> prod == '0);
      p_one_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(x_one)) |-> prod == $past(y_ext));
      p_all_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(both_ones)) |->
          prod == {{(N-1){1'b1}}, 1'b0, {(N-1){1'b0}}, 1'b1});
      p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> prod == '0);
    end else begin : g_comb_props
      p_follow_r9: assert property (@(posedge clk) disable iff (rst)
        prod == ref_p);
      p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (x_zero || y_zero) |-> prod == '0);
      p_one_r6: assert property (@(posedge clk) disable iff (rst)
        x_one |-> prod == y_ext);
      p_all_ones_r3: assert property (@(posedge clk) disable iff (rst)
        both_ones |-> prod == {{(N-1){1'b1}}, 1'b0, {(N-1){1'b0}}, 1'b1});
    end
  endgenerate
endmodule

bind vedic_mult vm_chk #(.N(N), .REG_OUT(REG_OUT)) u_vm_chk (
  .clk(clk), .rst(rst), .op_x(op_x), .op_y(op_y), .prod(prod)
);

// File: tb/sim_vedic_mult.sv
module sim_vedic_mult;
  logic clk = 1'b0;
  logic rst = 1'b1;

  logic [7:0]  x0 = '0, y0 = '0;
  logic [15:0] p0;
  logic [1:0]  x1 = '0, y1 = '0;
  logic [3:0]  p1;
  logic [31:0] x2 = '0, y2 = '0;
  logic [63:0] p2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] q0[$];
  logic [3:0]  q1[$];

  always #5 clk = ~clk;

  // R10: the three widths 8, 2 and 32 share one recursive structure
  vedic_mult #(.N(8),  .REG_OUT(1'b1)) u0 (.clk(clk), .rst(rst), .op_x(x0), .op_y(y0), .prod(p0));
  vedic_mult #(.N(2),  .REG_OUT(1'b1)) u1 (.clk(clk), .rst(rst), .op_x(x1), .op_y(y1), .prod(p1));
  vedic_mult #(.N(32), .REG_OUT(1'b0)) u2 (.clk(clk), .rst(rst), .op_x(x2), .op_y(y2), .prod(p2));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag8(input logic [7:0] a, input logic [7:0] b);
    if (a == 8'd13 && b == 8'd10) return "R4";
    if (a == 8'hFF && b == 8'hFF) return "R3";
    if (a == 8'd0 || b == 8'd0)   return "R5";
    if (a == 8'd1)                return "R6";
    return "R1";
  endfunction

  task automatic comb_case(input logic [31:0] a, input logic [31:0] b, input string req);
    x2 = a;
    y2 = b;
    #1;
    chk(req, p2, {32'd0, a} * {32'd0, b});
  endtask

  initial begin
    logic [7:0] pa, pb;
    // R8: reset holds the registered outputs at zero
    x0 = 8'hA5; y0 = 8'h3C; x1 = 2'd3; y1 = 2'd3;
    repeat (3) @(negedge clk);
    chk("R8", {48'd0, p0}, 64'd0);
    chk("R8", {60'd0, p1}, 64'd0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6: exhaustive sweep, one pair per clock
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      if (q0.size() > 0) chk(tag8(pa, pb), {48'd0, p0}, {48'd0, q0.pop_front()});
      if (q1.size() > 0) chk("R2", {60'd0, p1}, {60'd0, q1.pop_front()});
      pa = i[15:8]; pb = i[7:0];
      x0 = pa; y0 = pb;
      x1 = i[1:0]; y1 = i[3:2];
      q0.push_back({8'd0, pa} * {8'd0, pb});
      q1.push_back({2'd0, i[1:0]} * {2'd0, i[3:2]});
    end
    @(negedge clk);
    chk(tag8(pa, pb), {48'd0, p0}, {48'd0, q0.pop_front()});
    chk("R2", {60'd0, p1}, {60'd0, q1.pop_front()});

    // R7: output holds between edges, then shows the new product
    x0 = 8'd200; y0 = 8'd3;
    #2;
    chk("R7", {48'd0, p0}, 64'd65025);
    x0 = 8'd7;
    @(negedge clk);
    chk("R7", {48'd0, p0}, 64'd21);
    x0 = 8'd13; y0 = 8'd10;
    @(negedge clk);
    chk("R4", {48'd0, p0}, 64'd130);

    // R8: reset in mid traffic clears the register
    x0 = 8'hFF; y0 = 8'hFE; rst = 1'b1;
    @(negedge clk);
    chk("R8", {48'd0, p0}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {48'd0, p0}, 64'd64770);

    // R9 R10: combinational variant at N=32
    comb_case(32'd0, 32'hDEADBEEF, "R5");
    comb_case(32'h12345678, 32'd0, "R5");
    comb_case(32'd1, 32'hCAFEF00D, "R6");
    comb_case(32'hFFFFFFFF, 32'hFFFFFFFF, "R3");
    comb_case(32'hFFFFFFFF, 32'd1, "R6");
    comb_case(32'h80000000, 32'h80000000, "R10");
    comb_case(32'h0000FFFF, 32'hFFFF0000, "R10");
    for (int k = 0; k < 300; k++) begin
      comb_case($urandom, $urandom, "R9");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule